// File: doc/BRIEF.md
# Two-Wire Serial Memory Slave Controller

This block is the byte-level protocol engine of a two-wire bus slave that gives a host access to a 4096-byte non-volatile store. A line conditioner ahead of it turns the raw clock and data wires into single-cycle strobes: start, stop, clock rising and clock falling. It also supplies the filtered data level. The controller counts bits, shifts them in or out most significant bit first, and drives a registered pull-down request for the data wire. It produces the acknowledge or no-acknowledge answer in the ninth clock slot of every byte.

A transaction opens with a control byte that carries a fixed device code, three select bits and a direction bit. A write transaction then carries a two-byte word address and optionally data bytes. The data bytes go to a page buffer port, and a stop turns them into a commit request for the timed programming engine. A read transaction streams bytes from a 12-bit address pointer. The pointer is kept between transactions, so current-address, random and sequential reads all work. While the programming engine reports busy, the slave stays silent on every byte. A host can therefore poll with control bytes until it sees an acknowledge.

Top module: `tws_mem_slave`

## Requirements
- R1: A control byte is accepted when bits 7:4 equal 4'b1010 and bits 3:1 equal `sel_strap`. Bit 0 selects the direction: 1 is read and 0 is write. An accepted control byte is acknowledged.
- R2: After a write control byte, the next two bytes load the pointer, high byte first. The pointer becomes {high[3:0], low[7:0]}, and high[7:4] is ignored.
- R3: To acknowledge a byte, `sda_low` is 1 from the clock fall after the eighth bit until the clock fall that ends the ninth clock. `sda_low` only rises on a clock-fall strobe, and it is 0 after reset.
- R4: Each data byte that follows the address is acknowledged and appears for one cycle on `buf_wr_en`/`buf_wr_addr`/`buf_wr_data` at the current pointer.
- R5: `commit` pulses for one cycle on a stop only if at least one data byte was accepted since the last start. A repeated start, or a stop with no data byte, gives no commit.
- R6: While `busy` is 1, no byte is acknowledged, including a matching control byte. The slave then ignores traffic until the next start.
- R7: A current-address read (read control byte with no address phase) returns the byte at the pointer. After a read of address n this is n+1. After writes it is the address after the last one written, within its 32-byte page.
- R8: During reads the pointer advances by one over the full 12 bits after every byte sent. It runs freely across 32-byte pages and wraps from 0xFFF to 0x000.
- R9: Read data is driven as `sda_low` = not(bit), most significant bit first, starting at the fall that ends the acknowledge slot. If the master does not acknowledge, the data line stays released until the next start. Start and stop always release it.
- R10: A control byte with a wrong code or wrong select bits is not acknowledged. Later bytes up to the next start are not acknowledged, cause no buffer write, and leave the pointer unchanged.
- R11: A stop after the address bytes leaves the loaded pointer in place and gives no commit.
- R12: During a write the pointer advances only in its low 5 bits, so bytes past the end of a 32-byte page wrap to the page start.
- R13: A repeated start after the address bytes keeps the loaded pointer, so a following read returns data from that address (random read).

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| sel_strap | input | 3 | Strapped select value compared with control byte bits 3:1 |
| ev_start | input | 1 | One-cycle strobe: start or repeated start seen on the bus |
| ev_stop | input | 1 | One-cycle strobe: stop seen on the bus |
| ev_rise | input | 1 | One-cycle strobe: serial clock rose; `sda_in` is sampled in this cycle |
| ev_fall | input | 1 | One-cycle strobe: serial clock fell |
| sda_in | input | 1 | Filtered data line level |
| busy | input | 1 | Programming engine is running a write cycle |
| mem_rd_data | input | 8 | Array byte at `mem_rd_addr`, valid one cycle after the address |
| sda_low | output | 1 | Request to pull the data line low (registered) |
| mem_rd_addr | output | 12 | Address pointer, used as the array read address |
| buf_wr_en | output | 1 | Page buffer write strobe |
| buf_wr_addr | output | 12 | Page buffer write address |
| buf_wr_data | output | 8 | Page buffer write data |
| commit | output | 1 | One-cycle request to program the buffered page |

## Verification
The assertions assume the line conditioner behaves properly. Each strobe lasts exactly one cycle, no two strobes share a cycle, and rising and falling clock strobes alternate. They also assume `busy` only changes between transactions and that `mem_rd_data` follows `mem_rd_addr` within one cycle. The bench's bus tasks meet these assumptions by construction. Every strobe is a single-cycle pulse separated by several idle cycles, a start is followed by a clock fall, and bits always come as a rise and then a fall. `busy` is raised by the bench's memory model only on a commit and held for a fixed time, and the array model is a registered lookup of the pointer.

// File: rtl/tws_pkg.sv
package tws_pkg;
  localparam int          DW        = 8;
  localparam int          SEL_W     = 3;
  localparam int          CODE_W    = DW - 1 - SEL_W;
  localparam logic [3:0]  CTRL_CODE = 4'b1010;

  typedef enum logic [2:0] {
    S_IDLE,
    S_CTRL,
    S_ADDRH,
    S_ADDRL,
    S_WDATA,
    S_RDATA
  } tws_state_e;
endpackage

// File: rtl/tws_bit_engine.sv
// Bit-level shifter driven by line-conditioner strobes.
module tws_bit_engine #(
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          ev_start,
  input  logic          ev_stop,
  input  logic          ev_rise,
  input  logic          ev_fall,
  input  logic          sda_in,
  input  logic          tx_mode,
  input  logic          ack_en,
  input  logic          tx_load,
  input  logic [DW-1:0] tx_data,
  output logic          sda_low,
  output logic [DW-1:0] rx_byte,
  output logic          byte_done,
  output logic          ack_done,
  output logic          mack
);
  localparam int CW = $clog2(DW + 1);

  logic [CW-1:0] cnt;
  logic          in_ack;
  logic [DW-1:0] rx_q;
  logic [DW-1:0] tx_q;

  assign byte_done = ev_fall && !in_ack && (cnt == CW'(DW));
  assign ack_done  = ev_fall && in_ack;
  assign rx_byte   = rx_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt     <= '0;
      in_ack  <= 1'b0;
      sda_low <= 1'b0;
      mack    <= 1'b0;
      rx_q    <= '0;
      tx_q    <= '0;
    end else if (ev_start || ev_stop) begin
      cnt     <= '0;
      in_ack  <= 1'b0;
      sda_low <= 1'b0;
      mack    <= 1'b0;
    end else begin
      if (ev_rise) begin
        if (in_ack) begin
          mack <= ~sda_in;
        end else if (cnt != CW'(DW)) begin
          rx_q <= {rx_q[DW-2:0], sda_in};
          cnt  <= cnt + 1'b1;
        end
      end
      if (byte_done) begin
        // ninth clock: answer for received bytes, release for sent ones
        in_ack  <= 1'b1;
        sda_low <= tx_mode ? 1'b0 : ack_en;
      end else if (ack_done) begin
        in_ack <= 1'b0;
        cnt    <= '0;
        if (tx_load) begin
          tx_q    <= tx_data;
          sda_low <= ~tx_data[DW-1];
        end else begin
          sda_low <= 1'b0;
        end
      end else if (ev_fall && tx_mode && (cnt != '0)) begin
        tx_q    <= {tx_q[DW-2:0], 1'b0};
        sda_low <= ~tx_q[DW-2];
      end
    end
  end
endmodule

// File: rtl/tws_addr_ptr.sv
// Persistent word address pointer with sequential and in-page stepping.
module tws_addr_ptr #(
  parameter int AW = 12,
  parameter int PW = 5
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          ld_hi,
  input  logic          ld_lo,
  input  logic [AW-9:0] hi_bits,
  input  logic [7:0]    lo_bits,
  input  logic          inc_seq,
  input  logic          inc_page,
  output logic [AW-1:0] ptr
);
  always_ff @(posedge clk) begin
    if (rst) begin
      ptr <= '0;
    end else if (ld_hi) begin
      ptr[AW-1:8] <= hi_bits;
    end else if (ld_lo) begin
      ptr[7:0] <= lo_bits;
    end else if (inc_seq) begin
      ptr <= ptr + 1'b1;
    end else if (inc_page) begin
      ptr[PW-1:0] <= ptr[PW-1:0] + 1'b1;
    end
  end
endmodule

// File: rtl/tws_ctrl_match.sv
// Control byte decode: device code, select bits, direction.
module tws_ctrl_match
  import tws_pkg::*;
(
  input  logic [DW-1:0]    rx_byte,
  input  logic [SEL_W-1:0] sel_strap,
  output logic             hit,
  output logic             is_read
);
  assign hit     = (rx_byte[DW-1 -: CODE_W] == CTRL_CODE) &&
                   (rx_byte[SEL_W:1] == sel_strap);
  assign is_read = rx_byte[0];
endmodule

// File: rtl/tws_mem_slave.sv
module tws_mem_slave
  import tws_pkg::*;
#(
  parameter int ADDR_W = 12,
  parameter int PAGE_W = 5
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [SEL_W-1:0]  sel_strap,
  input  logic              ev_start,
  input  logic              ev_stop,
  input  logic              ev_rise,
  input  logic              ev_fall,
  input  logic              sda_in,
  input  logic              busy,
  input  logic [DW-1:0]     mem_rd_data,
  output logic              sda_low,
  output logic [ADDR_W-1:0] mem_rd_addr,
  output logic              buf_wr_en,
  output logic [ADDR_W-1:0] buf_wr_addr,
  output logic [DW-1:0]     buf_wr_data,
  output logic              commit
);
  localparam int HI_W = ADDR_W - 8;

  tws_state_e  st_q, st_d;
  logic        rd_armed, wrote;
  logic [DW-1:0] rx_byte;
  logic        byte_done, ack_done, mack;
  logic        ack_en, tx_load, tx_mode;
  logic        ctrl_hit, ctrl_rd;
  logic        ld_hi, ld_lo, inc_seq, inc_page;
  logic        wr_fire, arm_set, arm_clr, wrote_set;
  logic [ADDR_W-1:0] ptr;

  assign tx_mode     = (st_q == S_RDATA);
  assign mem_rd_addr = ptr;

  tws_bit_engine #(.DW(DW)) u_bits (
    .clk, .rst, .ev_start, .ev_stop, .ev_rise, .ev_fall, .sda_in,
    .tx_mode, .ack_en, .tx_load, .tx_data(mem_rd_data),
    .sda_low, .rx_byte, .byte_done, .ack_done, .mack
  );

  tws_ctrl_match u_match (
    .rx_byte, .sel_strap, .hit(ctrl_hit), .is_read(ctrl_rd)
  );

  tws_addr_ptr #(.AW(ADDR_W), .PW(PAGE_W)) u_ptr (
    .clk, .rst, .ld_hi, .ld_lo,
    .hi_bits(rx_byte[HI_W-1:0]), .lo_bits(rx_byte[7:0]),
    .inc_seq, .inc_page, .ptr
  );

  // byte-boundary decisions
  always_comb begin
    st_d      = st_q;
    ack_en    = 1'b0;
    tx_load   = 1'b0;
    ld_hi     = 1'b0;
    ld_lo     = 1'b0;
    inc_seq   = 1'b0;
    inc_page  = 1'b0;
    wr_fire   = 1'b0;
    arm_set   = 1'b0;
    arm_clr   = 1'b0;
    wrote_set = 1'b0;
    if (byte_done) begin
      unique case (st_q)
        S_CTRL: begin
          if (ctrl_hit && !busy) begin
            ack_en  = 1'b1;
            arm_set = ctrl_rd;
            st_d    = ctrl_rd ? S_RDATA : S_ADDRH;
          end else begin
            st_d = S_IDLE;
          end
        end
        S_ADDRH: begin
          if (!busy) begin
            ack_en = 1'b1;
            ld_hi  = 1'b1;
            st_d   = S_ADDRL;
          end else begin
            st_d = S_IDLE;
          end
        end
        S_ADDRL: begin
          if (!busy) begin
            ack_en = 1'b1;
            ld_lo  = 1'b1;
            st_d   = S_WDATA;
          end else begin
            st_d = S_IDLE;
          end
        end
        S_WDATA: begin
          if (!busy) begin
            ack_en    = 1'b1;
            wr_fire   = 1'b1;
            inc_page  = 1'b1;
            wrote_set = 1'b1;
          end else begin
            st_d = S_IDLE;
          end
        end
        S_RDATA: inc_seq = 1'b1;
        default: ;
      endcase
    end else if (ack_done && (st_q == S_RDATA)) begin
      arm_clr = 1'b1;
      if (rd_armed || mack) tx_load = 1'b1;
      else                  st_d    = S_IDLE;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      st_q        <= S_IDLE;
      rd_armed    <= 1'b0;
      wrote       <= 1'b0;
      buf_wr_en   <= 1'b0;
      buf_wr_addr <= '0;
      buf_wr_data <= '0;
      commit      <= 1'b0;
    end else begin
      buf_wr_en <= wr_fire;
      commit    <= 1'b0;
      if (wr_fire) begin
        buf_wr_addr <= ptr;
        buf_wr_data <= rx_byte;
      end
      if (ev_start) begin
        st_q     <= S_CTRL;
        wrote    <= 1'b0;
        rd_armed <= 1'b0;
      end else if (ev_stop) begin
        st_q     <= S_IDLE;
        commit   <= wrote && (st_q == S_WDATA);
        wrote    <= 1'b0;
        rd_armed <= 1'b0;
      end else begin
        st_q <= st_d;
        if (arm_set)      rd_armed <= 1'b1;
        else if (arm_clr) rd_armed <= 1'b0;
        if (wrote_set)    wrote    <= 1'b1;
      end
    end
  end
endmodule

// File: rtl/tws_mem_slave_chk.sv
module tws_mem_slave_chk #(
  parameter int AW = 12,
  parameter int PW = 5
) (
  input logic          clk,
  input logic          rst,
  input logic          ev_start,
  input logic          ev_stop,
  input logic          ev_fall,
  input logic          busy,
  input logic          sda_low,
  input logic          commit,
  input logic          buf_wr_en,
  input logic [AW-1:0] buf_wr_addr,
  input logic [AW-1:0] ptr,
  input logic          in_rd
);
  // R3: the pull-down only begins right after a clock-fall strobe
  p_pull_on_fall_r3: assert property (@(posedge clk) disable iff (rst)
    $rose(sda_low) |-> $past(ev_fall));

  // R9: start and stop release the data line
  p_release_r9: assert property (@(posedge clk) disable iff (rst)
    (ev_start || ev_stop) |=> !sda_low);

  // R6: no acknowledge is raised while the write cycle runs
  p_silent_busy_r6: assert property (@(posedge clk) disable iff (rst)
    (busy && $past(busy) && !$past(in_rd)) |-> !$rose(sda_low));

  // R5: commit only follows a stop strobe
  p_commit_stop_r5: assert property (@(posedge clk) disable iff (rst)
    commit |-> $past(ev_stop));

  // R12: after a buffered write the pointer remains in the same page
  p_same_page_r12: assert property (@(posedge clk) disable iff (rst)
    buf_wr_en |-> (buf_wr_addr[AW-1:PW] == ptr[AW-1:PW]));

  // R8: while reading, the pointer only ever steps by one
  p_seq_step_r8: assert property (@(posedge clk) disable iff (rst)
    (in_rd && $past(in_rd) && (ptr != $past(ptr))) |-> (ptr == $past(ptr) + 1'b1));
endmodule

bind tws_mem_slave tws_mem_slave_chk #(.AW(ADDR_W), .PW(PAGE_W)) u_chk (
  .clk(clk), .rst(rst), .ev_start(ev_start), .ev_stop(ev_stop),
  .ev_fall(ev_fall), .busy(busy), .sda_low(sda_low), .commit(commit),
  .buf_wr_en(buf_wr_en), .buf_wr_addr(buf_wr_addr), .ptr(mem_rd_addr),
  .in_rd(st_q == tws_pkg::S_RDATA)
);

// File: tb/tb_tws_mem_slave.sv
`timescale 1ns/1ps
module tb_tws_mem_slave;
  localparam int       GAP      = 3;
  localparam int       BUSY_CYC = 1500;
  localparam int       WDOG     = 150000;
  localparam logic [2:0] SEL    = 3'b101;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        ev_start = 0, ev_stop = 0, ev_rise = 0, ev_fall = 0;
  logic        m_sda = 1'b1;
  logic        busy = 1'b0;
  logic [7:0]  mem_rd_data = 8'h00;
  logic        sda_in, sda_low, buf_wr_en, commit;
  logic [11:0] mem_rd_addr, buf_wr_addr;
  logic [7:0]  buf_wr_data;

  int checks = 0;
  int errors = 0;
  int commits = 0;
  bit done = 0;

  typedef struct { string req; logic [11:0] a; logic [7:0] d; } item_t;
  item_t exp_rd_q[$];
  item_t got_rd_q[$];
  item_t exp_wr_q[$];
  item_t pend_q[$];
  logic [7:0] written [int];

  always #10 clk = ~clk;
  assign sda_in = m_sda & ~sda_low;

  tws_mem_slave dut (
    .clk, .rst, .sel_strap(SEL), .ev_start, .ev_stop, .ev_rise, .ev_fall,
    .sda_in, .busy, .mem_rd_data, .sda_low, .mem_rd_addr,
    .buf_wr_en, .buf_wr_addr, .buf_wr_data, .commit
  );

  function automatic logic [7:0] pat(int a);
    return 8'((a * 7) + (a >> 8) + 8'h3C);
  endfunction

  function automatic logic [7:0] rd_model(int a);
    if (written.exists(a)) return written[a];
    return pat(a);
  endfunction

  always @(posedge clk) mem_rd_data <= rd_model(int'(mem_rd_addr));

  task automatic chk(input string req, input logic [15:0] got, input logic [15:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s: got %0h expected %0h", req, got, exp);
    end
  endtask

  // array/programming model and scoreboard monitors, sampled after the edge
  int busy_cnt = 0;
  always begin
    @(posedge clk); #1;
    if (ev_start) pend_q.delete();
    if (buf_wr_en) begin
      if (exp_wr_q.size() == 0) begin
        chk("R10 unexpected buffer write", {4'h0, buf_wr_addr}, 16'hFFFF);
      end else begin
        item_t e;
        e = exp_wr_q.pop_front();
        chk({e.req, " write addr"}, {4'h0, buf_wr_addr}, {4'h0, e.a});
        chk({e.req, " write data"}, {8'h0, buf_wr_data}, {8'h0, e.d});
        pend_q.push_back(e);
      end
    end
    if (commit) begin
      commits++;
      foreach (pend_q[i]) written[int'(pend_q[i].a)] = pend_q[i].d;
      pend_q.delete();
      busy = 1'b1;
      busy_cnt = BUSY_CYC;
    end else if (busy_cnt > 0) begin
      busy_cnt--;
      if (busy_cnt == 0) busy = 1'b0;
    end
    while (exp_rd_q.size() > 0 && got_rd_q.size() > 0) begin
      item_t e, g;
      e = exp_rd_q.pop_front();
      g = got_rd_q.pop_front();
      chk({e.req, " read data"}, {8'h0, g.d}, {8'h0, e.d});
    end
  end

  task automatic gap();
    repeat (GAP) @(negedge clk);
  endtask

  task automatic bus_start();
    m_sda = 1'b1; gap();
    ev_start = 1'b1; @(negedge clk); ev_start = 1'b0;
    m_sda = 1'b0; gap();
    ev_fall = 1'b1; @(negedge clk); ev_fall = 1'b0; gap();
  endtask

  task automatic bus_stop();
    m_sda = 1'b0; gap();
    ev_stop = 1'b1; @(negedge clk); ev_stop = 1'b0;
    m_sda = 1'b1; gap();
  endtask

  task automatic clk_bit(input logic b, output logic seen);
    m_sda = b; gap();
    ev_rise = 1'b1; seen = sda_in; @(negedge clk); ev_rise = 1'b0; gap();
    ev_fall = 1'b1; @(negedge clk); ev_fall = 1'b0; gap();
  endtask

  task automatic send_byte(input logic [7:0] v, output logic ack);
    logic s;
    for (int i = 7; i >= 0; i--) clk_bit(v[i], s);
    clk_bit(1'b1, s);
    ack = ~s;
  endtask

  task automatic send_chk(input string req, input logic [7:0] v, input logic exp_ack);
    logic a;
    send_byte(v, a);
    chk({req, " ack"}, {15'h0, a}, {15'h0, exp_ack});
  endtask

  task automatic read_byte(input logic give_ack);
    logic s;
    logic [7:0] v;
    item_t g;
    for (int i = 7; i >= 0; i--) begin
      clk_bit(1'b1, s);
      v[i] = s;
    end
    clk_bit(~give_ack, s);
    if (!give_ack) chk("R9 line released on master nack", {15'h0, s}, 16'h1);
    g.req = ""; g.a = '0; g.d = v;
    got_rd_q.push_back(g);
  endtask

  task automatic exp_rd(input string req, input int a);
    item_t e;
    e.req = req; e.a = 12'(a); e.d = rd_model(a);
    exp_rd_q.push_back(e);
  endtask

  task automatic exp_wr(input string req, input int a, input logic [7:0] d);
    item_t e;
    e.req = req; e.a = 12'(a); e.d = d;
    exp_wr_q.push_back(e);
  endtask

  task automatic wait_idle();
    for (int i = 0; i < 5000 && busy; i++) @(negedge clk);
    repeat (4) @(negedge clk);
  endtask

  task automatic set_addr(input string req, input logic [7:0] hi, input logic [7:0] lo);
    bus_start();
    send_chk("R1", {4'b1010, SEL, 1'b0}, 1'b1);
    send_chk(req, hi, 1'b1);
    send_chk(req, lo, 1'b1);
  endtask

  task automatic read_seq(input string req, input int a, input int n);
    bus_start();
    send_chk("R1 read control", {4'b1010, SEL, 1'b1}, 1'b1);
    for (int i = 0; i < n; i++) begin
      exp_rd(req, (a + i) % 4096);
      read_byte(i != n - 1);
    end
    bus_stop();
  endtask

  initial begin
    int c0;
    repeat (5) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    chk("R3 reset sda_low", {15'h0, sda_low}, 16'h0);
    chk("R5 reset commit", {15'h0, commit}, 16'h0);
    chk("R4 reset buf_wr_en", {15'h0, buf_wr_en}, 16'h0);
    chk("R7 reset pointer", {4'h0, mem_rd_addr}, 16'h0);

    // R4 R5: single byte write at 0x123
    set_addr("R2", 8'h01, 8'h23);
    exp_wr("R4", 'h123, 8'hA5);
    send_chk("R4", 8'hA5, 1'b1);
    c0 = commits;
    bus_stop();
    repeat (3) @(negedge clk);
    chk("R5 commit on stop", 16'(commits - c0), 16'd1);

    // R6: polling while busy
    chk("R6 busy after commit", {15'h0, busy}, 16'h1);
    bus_start();
    send_chk("R6 control while busy", {4'b1010, SEL, 1'b0}, 1'b0);
    send_chk("R6 byte after nack", 8'h00, 1'b0);
    bus_stop();
    wait_idle();
    c0 = commits;
    bus_start();
    send_chk("R6 poll after busy", {4'b1010, SEL, 1'b0}, 1'b1);
    bus_stop();
    repeat (3) @(negedge clk);
    chk("R5 no commit without data", 16'(commits - c0), 16'd0);

    // R7: current address read after write at 0x123
    read_seq("R7", 'h124, 1);

    // R13 R8: random read at 0xFFE with wrap
    set_addr("R2", 8'h0F, 8'hFE);
    read_seq("R8 R13", 'hFFE, 4);
    read_seq("R7 after wrap", 'h002, 1);

    // R10: wrong select and wrong code
    c0 = commits;
    bus_start();
    send_chk("R10 wrong select", {4'b1010, SEL ^ 3'b001, 1'b0}, 1'b0);
    send_chk("R10 ignored", 8'h00, 1'b0);
    send_chk("R10 ignored", 8'h10, 1'b0);
    send_chk("R10 ignored", 8'h77, 1'b0);
    bus_stop();
    bus_start();
    send_chk("R10 wrong code", {4'b1011, SEL, 1'b0}, 1'b0);
    send_chk("R10 ignored", 8'h05, 1'b0);
    bus_stop();
    repeat (3) @(negedge clk);
    chk("R10 no commit", 16'(commits - c0), 16'd0);
    read_seq("R10 pointer kept", 'h003, 1);

    // R11 R2: stop after address, upper nibble ignored
    c0 = commits;
    set_addr("R2", 8'hF5, 8'h67);
    bus_stop();
    repeat (3) @(negedge clk);
    chk("R11 no commit", 16'(commits - c0), 16'd0);
    read_seq("R11 R2", 'h567, 1);

    // R12: page write wraps within the 32-byte page
    set_addr("R2", 8'h00, 8'h5E);
    exp_wr("R12", 'h05E, 8'h11);
    send_chk("R4", 8'h11, 1'b1);
    exp_wr("R12", 'h05F, 8'h22);
    send_chk("R4", 8'h22, 1'b1);
    exp_wr("R12", 'h040, 8'h33);
    send_chk("R12", 8'h33, 1'b1);
    exp_wr("R12", 'h041, 8'h44);
    send_chk("R12", 8'h44, 1'b1);
    c0 = commits;
    bus_stop();
    repeat (3) @(negedge clk);
    chk("R5 page commit", 16'(commits - c0), 16'd1);
    wait_idle();
    set_addr("R2", 8'h00, 8'h5D);
    read_seq("R8 page crossing", 'h05D, 5);
    set_addr("R2", 8'h00, 8'h40);
    read_seq("R12 wrapped data", 'h040, 2);

    // R5 R13: repeated start after data discards the write
    c0 = commits;
    set_addr("R2", 8'h02, 8'h00);
    exp_wr("R4", 'h200, 8'h99);
    send_chk("R4", 8'h99, 1'b1);
    read_seq("R13 read after restart", 'h201, 1);
    repeat (3) @(negedge clk);
    chk("R5 no commit on repeated start", 16'(commits - c0), 16'd0);
    set_addr("R2", 8'h02, 8'h00);
    read_seq("R5 discarded data", 'h200, 1);

    repeat (10) @(negedge clk);
    chk("R7 all reads matched", 16'(exp_rd_q.size() + got_rd_q.size()), 16'd0);
    chk("R4 all writes seen", 16'(exp_wr_q.size()), 16'd0);
    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (WDOG) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog (all requirements): got timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule